// File: doc/BRIEF.md
# Display Raster Timing Counter

This block produces the raster timing for one display pipe. A horizontal pixel position and a vertical line index run from programmable totals. From them it derives the sync and blanking outputs, and it raises single-cycle event pulses at three points in each frame: the start of vertical blanking, the start of a new frame, and the start of vertical sync. The vblank-start and vsync-start events are placed at the leading edge of horizontal sync rather than at the beginning of a line. The frame-start event is placed at the start of horizontal blanking, and a programmable number of extra lines can push it later.

Alongside the raster the block keeps four values that software reads to locate the beam. The first is a line readout that follows the offset convention: it advances at horizontal sync, so on the first active line it still shows the last line of the previous frame. The second is a running pixel index within the frame. The third is a 24-bit frame count. The fourth is a copy of an external free-running time value, captured at every vblank start. Timing inputs are shadow values. The block takes them into its working set only while it is stopped, or at the vblank-start point. Software can therefore rewrite them at any time and the change never tears a frame.

When interlace is selected, the vertical values describe a full frame and the block runs one field of half that height.

Top module: `disp_timing_unit`

## Requirements
- R1: While running, the pixel position counts 0 up to cfg_htotal-1 and then returns to 0 and advances the line, and the line counts 0 up to cfg_vtotal-1 and then returns to 0. The wrap is taken whenever the count has reached or passed the total minus one. hsync is high for positions in [cfg_hsync_start, cfg_hsync_end). blank is high when the block is stopped, for positions at or beyond cfg_hblank, and for lines in [cfg_vblank_start, cfg_vblank_end).
- R2: ev_vblank is high for exactly one cycle. That cycle is the one after the cycle whose position is cfg_hsync_start on line cfg_vblank_start-1.
- R3: frame_count rises by one, modulo 2^24, in the same cycle that ev_vblank is high, and holds at all other times.
- R4: In the cycle that ev_vblank is high, frame_ts holds the value ts_in had in the preceding cycle. At other times frame_ts holds.
- R5: A change to the timing inputs made while running has no effect on the outputs until a vblank-start point. At that clock edge the whole working set is replaced. While stopped, the working set follows the inputs every cycle.
- R6: ev_frame_start is high for one cycle. That cycle is the one after position cfg_hblank on line cfg_vblank_start+d, where d is the 2-bit value cfg_fs_delay (0 to 3).
- R7: ev_vsync pulses in the cycle after position cfg_hsync_start on line cfg_vsync_start. vsync rises in that same cycle. vsync falls in the cycle after position cfg_hsync_start on line cfg_vsync_end.
- R8: scanline takes the current line index in the cycle after each cfg_hsync_start position. So on line 0 before sync it reads vtotal-1, and just after vblank start it reads cfg_vblank_start-1. While stopped it reads vtotal-1.
- R9: pixel_count is 0 in the first running cycle and in every cycle at position 0 of line 0. In all other cycles it is one more than in the previous cycle.
- R10: With cfg_interlace=1, the working vertical total and vblank end are the programmed values halved and rounded down. Vblank start is halved and rounded up. Vsync start and vsync end are halved and rounded down.
- R11: A synchronous active-high rst clears frame_count, frame_ts, pixel_count, scanline, vsync and all events. With en low the raster is held stopped. The first cycle after en is sampled high is position 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable for the raster |
| cfg_htotal | input | 12 | Shadow pixels per line |
| cfg_hblank | input | 12 | Shadow first blank pixel of a line |
| cfg_hsync_start | input | 12 | Shadow first hsync pixel |
| cfg_hsync_end | input | 12 | Shadow first pixel after hsync |
| cfg_vtotal | input | 12 | Shadow lines per frame |
| cfg_vblank_start | input | 12 | Shadow first blank line |
| cfg_vblank_end | input | 12 | Shadow first line after vertical blank |
| cfg_vsync_start | input | 12 | Shadow first vsync line |
| cfg_vsync_end | input | 12 | Shadow first line after vsync |
| cfg_interlace | input | 1 | Shadow field mode select |
| cfg_fs_delay | input | 2 | Shadow extra lines before frame start |
| ts_in | input | 32 | Free-running time value |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Blanking |
| scanline | output | 12 | Line readout with hsync-edge offset |
| pixel_count | output | 24 | Pixel index within frame |
| frame_count | output | 24 | Frame count |
| frame_ts | output | 32 | Time value captured at vblank start |
| ev_vblank | output | 1 | Vblank-start pulse |
| ev_frame_start | output | 1 | Frame-start pulse |
| ev_vsync | output | 1 | Vsync-start pulse |

## Verification
The bench rewrites the timing inputs at random points mid-frame. A design that applied them at once, or at the line boundary, would bend the hsync and blank pattern before the vblank event. It is also exercised with every frame-start delay and with odd interlaced values, where rounding vblank start down instead of up moves the vblank event and the capture one line early. Other cases covered are the scanline readout on line 0 before the first sync, and a shrinking htotal latched while the position already lies beyond the new total, which a design with an equality wrap would run past. The last case is a stop and restart, where the pixel index and line readout must begin again from their stopped values.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
    localparam int H_W   = 12;
    localparam int V_W   = 12;
    localparam int FC_W  = 24;
    localparam int TS_W  = 32;
    localparam int PIX_W = H_W + V_W;
    localparam int FSD_W = 2;

    typedef struct packed {
        logic [H_W-1:0]   htotal;
        logic [H_W-1:0]   hblank;
        logic [H_W-1:0]   hs_start;
        logic [H_W-1:0]   hs_end;
        logic [V_W-1:0]   vtotal;
        logic [V_W-1:0]   vb_start;
        logic [V_W-1:0]   vb_end;
        logic [V_W-1:0]   vs_start;
        logic [V_W-1:0]   vs_end;
        logic [FSD_W-1:0] fs_delay;
    } timing_t;

    // Field-height adjustment for interlaced operation.
    function automatic timing_t field_adjust(timing_t raw, logic interlace);
        timing_t t;
        logic [V_W:0] vbs_up;
        t = raw;
        vbs_up = ({1'b0, raw.vb_start} + 1'b1) >> 1;
        if (interlace) begin
            t.vtotal   = raw.vtotal >> 1;
            t.vb_end   = raw.vb_end >> 1;
            t.vb_start = vbs_up[V_W-1:0];
            t.vs_start = raw.vs_start >> 1;
            t.vs_end   = raw.vs_end >> 1;
        end
        return t;
    endfunction
endpackage

// File: rtl/dtu_shadow.sv
module dtu_shadow
    import dtu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    load,
    input  timing_t pend,
    output timing_t act
);
    always_ff @(posedge clk) begin
        if (rst || !run || load)
            act <= pend;
    end

    // R5
    hold_between_latch_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run && !$past(load)) |-> $stable(act))
        else $error("working timing changed outside a latch point");
endmodule

// File: rtl/dtu_raster.sv
module dtu_raster
    import dtu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  timing_t        act,
    output logic           run,
    output logic [H_W-1:0] hpos,
    output logic [V_W-1:0] vline,
    output logic           frame_last,
    output logic           hsync,
    output logic           blank
);
    logic line_last;
    logic field_last;

    assign line_last  = hpos  >= act.htotal - 1'b1;
    assign field_last = vline >= act.vtotal - 1'b1;
    assign frame_last = line_last && field_last;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run   <= 1'b0;
            hpos  <= '0;
            vline <= '0;
        end else begin
            run <= 1'b1;
            if (run) begin
                if (line_last) begin
                    hpos  <= '0;
                    vline <= field_last ? '0 : vline + 1'b1;
                end else begin
                    hpos <= hpos + 1'b1;
                end
            end
        end
    end

    assign hsync = run && (hpos >= act.hs_start) && (hpos < act.hs_end);
    assign blank = !run || (hpos >= act.hblank) ||
                   ((vline >= act.vb_start) && (vline < act.vb_end));

    // R1
    hpos_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run && hpos != '0) |-> hpos == H_W'($past(hpos) + 1'b1))
        else $error("pixel position skipped");

    // R1
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run && hpos != '0) |-> $stable(vline))
        else $error("line changed inside a line");

    // R11
    stopped_home_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> (hpos == '0 && vline == '0))
        else $error("raster moved while stopped");
endmodule

// File: rtl/dtu_events.sv
module dtu_events
    import dtu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [H_W-1:0] hpos,
    input  logic [V_W-1:0] vline,
    input  timing_t        act,
    output logic           at_hs,
    output logic           vb_hit,
    output logic           ev_vblank,
    output logic           ev_frame_start,
    output logic           ev_vsync,
    output logic           vsync
);
    logic fs_hit;
    logic vs_hit;
    logic ve_hit;
    logic at_hb;
    logic [V_W-1:0] fs_line;

    assign fs_line = act.vb_start + V_W'(act.fs_delay);
    assign at_hs   = run && (hpos == act.hs_start);
    assign at_hb   = run && (hpos == act.hblank);
    assign vb_hit  = at_hs && (vline == act.vb_start - 1'b1);
    assign fs_hit  = at_hb && (vline == fs_line);
    assign vs_hit  = at_hs && (vline == act.vs_start);
    assign ve_hit  = at_hs && (vline == act.vs_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_vblank      <= 1'b0;
            ev_frame_start <= 1'b0;
            ev_vsync       <= 1'b0;
            vsync          <= 1'b0;
        end else begin
            ev_vblank      <= vb_hit;
            ev_frame_start <= fs_hit;
            ev_vsync       <= vs_hit;
            if (!run)
                vsync <= 1'b0;
            else if (vs_hit)
                vsync <= 1'b1;
            else if (ve_hit)
                vsync <= 1'b0;
        end
    end

    // R2
    vblank_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ev_vblank |=> !ev_vblank)
        else $error("vblank event longer than one cycle");

    // R6
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ev_frame_start |=> !ev_frame_start)
        else $error("frame-start event longer than one cycle");

    // R7
    vsync_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ev_vsync |=> !ev_vsync)
        else $error("vsync event longer than one cycle");
endmodule

// File: rtl/dtu_counters.sv
module dtu_counters
    import dtu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             at_hs,
    input  logic             vb_hit,
    input  logic             frame_last,
    input  logic [V_W-1:0]   vline,
    input  logic [V_W-1:0]   pend_vtotal,
    input  logic [TS_W-1:0]  ts_in,
    output logic [V_W-1:0]   scanline,
    output logic [PIX_W-1:0] pixel_count,
    output logic [FC_W-1:0]  frame_count,
    output logic [TS_W-1:0]  frame_ts
);
    always_ff @(posedge clk) begin
        if (rst) begin
            scanline    <= '0;
            pixel_count <= '0;
            frame_count <= '0;
            frame_ts    <= '0;
        end else begin
            if (!run) begin
                scanline    <= pend_vtotal - 1'b1;
                pixel_count <= '0;
            end else begin
                if (at_hs)
                    scanline <= vline;
                pixel_count <= frame_last ? '0 : pixel_count + 1'b1;
            end
            if (vb_hit) begin
                frame_count <= frame_count + 1'b1;
                frame_ts    <= ts_in;
            end
        end
    end

    // R3
    frame_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(vb_hit) |-> frame_count == FC_W'($past(frame_count) + 1'b1))
        else $error("frame count did not step");

    // R3
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(vb_hit) |-> $stable(frame_count))
        else $error("frame count moved without a vblank");

    // R4
    ts_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $past(vb_hit) |-> frame_ts == $past(ts_in))
        else $error("timestamp not captured");
endmodule

// File: rtl/disp_timing_unit.sv
module disp_timing_unit
    import dtu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [H_W-1:0]   cfg_htotal,
    input  logic [H_W-1:0]   cfg_hblank,
    input  logic [H_W-1:0]   cfg_hsync_start,
    input  logic [H_W-1:0]   cfg_hsync_end,
    input  logic [V_W-1:0]   cfg_vtotal,
    input  logic [V_W-1:0]   cfg_vblank_start,
    input  logic [V_W-1:0]   cfg_vblank_end,
    input  logic [V_W-1:0]   cfg_vsync_start,
    input  logic [V_W-1:0]   cfg_vsync_end,
    input  logic             cfg_interlace,
    input  logic [FSD_W-1:0] cfg_fs_delay,
    input  logic [TS_W-1:0]  ts_in,
    output logic             hsync,
    output logic             vsync,
    output logic             blank,
    output logic [V_W-1:0]   scanline,
    output logic [PIX_W-1:0] pixel_count,
    output logic [FC_W-1:0]  frame_count,
    output logic [TS_W-1:0]  frame_ts,
    output logic             ev_vblank,
    output logic             ev_frame_start,
    output logic             ev_vsync
);
    timing_t        pend_raw;
    timing_t        pend;
    timing_t        act;
    logic           run;
    logic [H_W-1:0] hpos;
    logic [V_W-1:0] vline;
    logic           frame_last;
    logic           at_hs;
    logic           vb_hit;

    assign pend_raw = '{htotal:   cfg_htotal,
                        hblank:   cfg_hblank,
                        hs_start: cfg_hsync_start,
                        hs_end:   cfg_hsync_end,
                        vtotal:   cfg_vtotal,
                        vb_start: cfg_vblank_start,
                        vb_end:   cfg_vblank_end,
                        vs_start: cfg_vsync_start,
                        vs_end:   cfg_vsync_end,
                        fs_delay: cfg_fs_delay};
    assign pend = field_adjust(pend_raw, cfg_interlace);

    dtu_shadow u_shadow (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .load (vb_hit),
        .pend (pend),
        .act  (act)
    );

    dtu_raster u_raster (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .act        (act),
        .run        (run),
        .hpos       (hpos),
        .vline      (vline),
        .frame_last (frame_last),
        .hsync      (hsync),
        .blank      (blank)
    );

    dtu_events u_events (
        .clk            (clk),
        .rst            (rst),
        .run            (run),
        .hpos           (hpos),
        .vline          (vline),
        .act            (act),
        .at_hs          (at_hs),
        .vb_hit         (vb_hit),
        .ev_vblank      (ev_vblank),
        .ev_frame_start (ev_frame_start),
        .ev_vsync       (ev_vsync),
        .vsync          (vsync)
    );

    dtu_counters u_counters (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .at_hs       (at_hs),
        .vb_hit      (vb_hit),
        .frame_last  (frame_last),
        .vline       (vline),
        .pend_vtotal (pend.vtotal),
        .ts_in       (ts_in),
        .scanline    (scanline),
        .pixel_count (pixel_count),
        .frame_count (frame_count),
        .frame_ts    (frame_ts)
    );

    // R8
    scan_moves_at_sync_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run && !$past(at_hs)) |-> $stable(scanline))
        else $error("scanline moved away from hsync start");
endmodule

// File: tb/disp_timing_unit_test.sv
module disp_timing_unit_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int ht, hb, hss, hse, vt, vbs, vbe, vss, vse, fsd;
    } tm_t;

    logic        clk = 1'b0;
    logic        rst, en, cfg_interlace;
    logic [11:0] cfg_htotal, cfg_hblank, cfg_hsync_start, cfg_hsync_end;
    logic [11:0] cfg_vtotal, cfg_vblank_start, cfg_vblank_end, cfg_vsync_start, cfg_vsync_end;
    logic [1:0]  cfg_fs_delay;
    logic [31:0] ts_in;
    logic        hsync, vsync, blank, ev_vblank, ev_frame_start, ev_vsync;
    logic [11:0] scanline;
    logic [23:0] pixel_count, frame_count;
    logic [31:0] frame_ts;

    disp_timing_unit uut (
        .clk(clk), .rst(rst), .en(en),
        .cfg_htotal(cfg_htotal), .cfg_hblank(cfg_hblank),
        .cfg_hsync_start(cfg_hsync_start), .cfg_hsync_end(cfg_hsync_end),
        .cfg_vtotal(cfg_vtotal), .cfg_vblank_start(cfg_vblank_start),
        .cfg_vblank_end(cfg_vblank_end), .cfg_vsync_start(cfg_vsync_start),
        .cfg_vsync_end(cfg_vsync_end), .cfg_interlace(cfg_interlace),
        .cfg_fs_delay(cfg_fs_delay), .ts_in(ts_in),
        .hsync(hsync), .vsync(vsync), .blank(blank), .scanline(scanline),
        .pixel_count(pixel_count), .frame_count(frame_count), .frame_ts(frame_ts),
        .ev_vblank(ev_vblank), .ev_frame_start(ev_frame_start), .ev_vsync(ev_vsync)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string phase = "R1";

    // bench-side stimulus state
    tm_t raw;
    bit  v_il, v_rst, v_en;
    int  v_ts;

    // reference model state
    tm_t ma;
    bit  mrun, mevv, mevf, mevs, mvs;
    int  mh, mv, mscan, mpix, mfc;
    longint mts;

    function automatic tm_t eff(tm_t r, bit il);
        tm_t t = r;
        if (il) begin
            t.vt  = r.vt / 2;
            t.vbe = r.vbe / 2;
            t.vbs = (r.vbs + 1) / 2;
            t.vss = r.vss / 2;
            t.vse = r.vse / 2;
        end
        return t;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s [%s phase] t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
        end
    endtask

    task automatic compare();
        bit ehs, ebl;
        ehs = mrun && mh >= ma.hss && mh < ma.hse;
        ebl = !mrun || mh >= ma.hb || (mv >= ma.vbs && mv < ma.vbe);
        chk(hsync == ehs, "R1 hsync", hsync, ehs);
        chk(blank == ebl, "R1 blank", blank, ebl);
        chk(ev_vblank == mevv, "R2 ev_vblank", ev_vblank, mevv);
        chk(frame_count == 24'(mfc), "R3 frame_count", frame_count, mfc);
        chk(frame_ts == 32'(mts), "R4 frame_ts", frame_ts, mts);
        chk(ev_frame_start == mevf, "R6 ev_frame_start", ev_frame_start, mevf);
        chk(ev_vsync == mevs, "R7 ev_vsync", ev_vsync, mevs);
        chk(vsync == mvs, "R7 vsync", vsync, mvs);
        chk(scanline == 12'(mscan), "R8 scanline", scanline, mscan);
        chk(pixel_count == 24'(mpix), "R9 pixel_count", pixel_count, mpix);
    endtask

    task automatic drive();
        rst = v_rst; en = v_en; cfg_interlace = v_il; ts_in = 32'(v_ts);
        cfg_htotal = 12'(raw.ht); cfg_hblank = 12'(raw.hb);
        cfg_hsync_start = 12'(raw.hss); cfg_hsync_end = 12'(raw.hse);
        cfg_vtotal = 12'(raw.vt); cfg_vblank_start = 12'(raw.vbs);
        cfg_vblank_end = 12'(raw.vbe); cfg_vsync_start = 12'(raw.vss);
        cfg_vsync_end = 12'(raw.vse); cfg_fs_delay = 2'(raw.fsd);
    endtask

    task automatic mstep();
        tm_t pe;
        bit vb, fs, vs, ve, ahs, hl, vl;
        pe  = eff(raw, v_il);
        ahs = mrun && mh == ma.hss;
        vb  = ahs && mv == ma.vbs - 1;
        fs  = mrun && mh == ma.hb && mv == ma.vbs + ma.fsd;
        vs  = ahs && mv == ma.vss;
        ve  = ahs && mv == ma.vse;
        hl  = mh >= ma.ht - 1;
        vl  = mv >= ma.vt - 1;
        if (v_rst) begin
            mrun = 0; mh = 0; mv = 0; ma = pe;
            mevv = 0; mevf = 0; mevs = 0; mvs = 0;
            mscan = 0; mpix = 0; mfc = 0; mts = 0;
        end else begin
            mevv = vb; mevf = fs; mevs = vs;
            if (!mrun) mvs = 0; else if (vs) mvs = 1; else if (ve) mvs = 0;
            if (!mrun) begin
                mscan = pe.vt - 1; mpix = 0;
            end else begin
                if (ahs) mscan = mv;
                mpix = (hl && vl) ? 0 : mpix + 1;
            end
            if (vb) begin
                mfc = (mfc + 1) % (1 << 24);
                mts = 32'(v_ts);
            end
            if (!mrun || vb) ma = pe;
            if (!v_en) begin
                mrun = 0; mh = 0; mv = 0;
            end else begin
                if (mrun) begin
                    if (hl) begin mh = 0; mv = vl ? 0 : mv + 1; end
                    else mh = mh + 1;
                end
                mrun = 1;
            end
        end
    endtask

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            v_ts = v_ts + 1;
            drive();
            mstep();
        end
    endtask

    function automatic tm_t base_cfg();
        tm_t t;
        t.ht = 20; t.hb = 14; t.hss = 16; t.hse = 18;
        t.vt = 12; t.vbs = 8; t.vbe = 12; t.vss = 9; t.vse = 10; t.fsd = 0;
        return t;
    endfunction

    function automatic tm_t rand_cfg(output bit il);
        tm_t e, r;
        e.ht  = 8 + int'($urandom % 33);
        e.hb  = 2 + int'($urandom % (e.ht - 6));
        e.hss = e.hb + 1 + int'($urandom % 2);
        e.hse = e.hss + 1 + int'($urandom % 2);
        e.vt  = 8 + int'($urandom % 25);
        e.vbs = 2 + int'($urandom % (e.vt - 6));
        e.vbe = e.vbs + int'($urandom % (e.vt - e.vbs + 1));
        e.vss = e.vbs + int'($urandom % 3);
        e.vse = e.vss + 1 + int'($urandom % 2);
        e.fsd = int'($urandom % 4);
        il = 1'($urandom % 2);
        r = e;
        if (il) begin
            r.vt  = 2 * e.vt + int'($urandom % 2);
            r.vbe = 2 * e.vbe + int'($urandom % 2);
            r.vbs = 2 * e.vbs - int'($urandom % 2);
            r.vss = 2 * e.vss + int'($urandom % 2);
            r.vse = 2 * e.vse + int'($urandom % 2);
        end
        return r;
    endfunction

    function automatic int flen(tm_t r, bit il);
        tm_t e = eff(r, il);
        return e.ht * e.vt;
    endfunction

    initial begin
        int seen;
        void'($urandom(32'd20417));
        raw = base_cfg(); v_il = 0; v_rst = 1; v_en = 0; v_ts = 1000;
        drive();
        mstep();

        // reset state
        phase = "R11";
        run_cycles(3);
        chk(frame_count == 0 && pixel_count == 0 && scanline == 0, "R11 reset counters", frame_count, 0);
        chk(!ev_vblank && !ev_frame_start && !ev_vsync && !vsync, "R11 reset events", ev_vblank, 0);
        v_rst = 0;
        run_cycles(4);
        chk(scanline == 11, "R8 stopped readout", scanline, 11);
        v_en = 1;

        // directed base timing
        phase = "R1";
        run_cycles(4 * 240);

        // every frame-start delay
        phase = "R6";
        for (int d = 1; d < 4; d++) begin
            raw.fsd = d;
            run_cycles(2 * 240 + 7);
        end

        // interlaced values whose halves match the base timing
        phase = "R10";
        raw = base_cfg(); raw.vt = 25; raw.vbs = 15; raw.vbe = 25; raw.vss = 19; raw.vse = 21;
        v_il = 1;
        run_cycles(3 * 240);

        // shrink htotal while the position may be past it
        phase = "R5";
        raw = base_cfg(); v_il = 0;
        run_cycles(240);
        raw.ht = 9; raw.hb = 4; raw.hss = 5; raw.hse = 6;
        run_cycles(240 + 3 * 108);

        // random mid-frame reprogramming
        for (int k = 0; k < 10; k++) begin
            int oldlen;
            bit il;
            tm_t nr;
            oldlen = flen(raw, v_il);
            phase = "R5";
            run_cycles(1 + int'($urandom % oldlen));
            nr = rand_cfg(il);
            raw = nr; v_il = il;
            run_cycles(oldlen + 3 * flen(raw, v_il));
        end

        // count vblank events over a known span of the base timing
        phase = "R2";
        raw = base_cfg(); v_il = 0;
        run_cycles(2 * 1600);
        seen = 0;
        for (int i = 0; i < 5 * 240; i++) begin
            run_cycles(1);
            if (ev_vblank) seen++;
        end
        chk(seen == 5, "R2 vblank events per five frames", seen, 5);

        // stop and restart
        phase = "R11";
        v_en = 0;
        run_cycles(5);
        v_en = 1;
        run_cycles(2 * 240);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule